// File: doc/BRIEF.md
# Duplicated-Store Commit Buffer

This block sits between a core's store path and the write port of data memory. Software issues every program store twice. A one-bit copy tag marks each instance as the first or the second copy. The buffer holds stores until both copies of a pair are in. It compares the two copies, and it releases to memory only pairs whose address and data agree. A single corrupted copy therefore never reaches memory.

Pairs leave strictly in program order from the oldest entry. A pair that has not been checked, or that failed its check, stays at the head and holds back everything behind it. When the buffer fills behind such a head, a sticky fault flag is raised for the rest of the system to act on. Recovery is left to the system. The nth first copy always pairs with the nth second copy, and either copy of a pair may arrive first. Software must keep the two copies of a store close enough together that the buffer can hold everything issued between them.

Top module: `dup_store_commit_buf`

## Requirements
- R1: After reset the buffer is empty: `mem_valid` is 0, `fault` is 0 and `in_ready` is 1.
- R2: `in_copy` = 0 marks a first copy and `in_copy` = 1 marks a second copy. The nth accepted first copy pairs with the nth accepted second copy, whichever of the two arrives first.
- R3: A pair whose two copies carry equal address and equal data becomes validated. It produces exactly one memory write, carrying that address and that data.
- R4: Memory writes leave in pair order and are taken only from the oldest pair, and only when that pair is validated. Once `mem_valid` is raised, `mem_addr` and `mem_data` hold until `mem_ready` accepts the write. The entry is freed on the accepting cycle.
- R5: An oldest pair whose partner is missing, or whose copies differ in address or data, produces no write and blocks every later pair.
- R6: A pair occupies one entry from the arrival of its first-arriving copy until its write is accepted. When DEPTH entries are occupied, `in_ready` is 0 and no store is accepted.
- R7: `fault` rises one cycle after a cycle in which all DEPTH entries are occupied and the oldest pair is not validated. A full buffer with a validated oldest pair raises no fault. Once set, `fault` stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A store copy is offered |
| in_ready | output | 1 | Buffer can accept a store copy |
| in_copy | input | 1 | 0 = first copy, 1 = second copy |
| in_addr | input | AW | Store address |
| in_data | input | DW | Store data |
| mem_valid | output | 1 | A checked store is offered to memory |
| mem_ready | input | 1 | Memory accepts the offered store |
| mem_addr | output | AW | Address of the offered store |
| mem_data | output | DW | Data of the offered store |
| fault | output | 1 | Sticky fault: buffer filled behind an unchecked head |

## Verification
The bench sends pairs in both copy orders and in bursts where several leading copies run ahead of their partners. A design that paired by arrival instead of by sequence would then compare the wrong stores and stall or emit wrong data. A single-bit data mismatch is placed behind a good pair. A design that skipped the bad head, or that let later validated pairs overtake it, would produce writes the bench does not expect. Two full-buffer cases are told apart: one with only unpartnered copies, which must raise a fault and refuse input, and one with a validated head held by memory back-pressure, where a design that treated every full buffer as a fault would be caught. Random memory stalls check that an offered write never changes before it is accepted.

// File: rtl/dup_store_commit_buf.sv
module dup_store_commit_buf #(
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  parameter int DW    = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic          in_copy,
  input  logic [AW-1:0] in_addr,
  input  logic [DW-1:0] in_data,
  output logic          mem_valid,
  input  logic          mem_ready,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_data,
  output logic          fault
);
  localparam int IW = $clog2(DEPTH);
  localparam int CW = IW + 2;

  logic [CW-1:0] seq0, seq1, head;
  logic [AW-1:0] addr_q [DEPTH];
  logic [DW-1:0] data_q [DEPTH];
  logic [DEPTH-1:0] ok_q;

  logic signed [CW-1:0] lead, pdiff;
  logic [CW-1:0] front, occ, my_seq, other_seq;
  logic [IW-1:0] slot, hslot;
  logic full, partner, accept, commit, same;

  assign lead      = seq0 - seq1;
  assign front     = (lead > 0) ? seq0 : seq1;
  assign occ       = front - head;
  assign full      = (occ == CW'(DEPTH));
  assign my_seq    = in_copy ? seq1 : seq0;
  assign other_seq = in_copy ? seq0 : seq1;
  assign pdiff     = other_seq - my_seq;
  assign partner   = (pdiff > 0);
  assign slot      = my_seq[IW-1:0];
  assign hslot     = head[IW-1:0];
  assign same      = (addr_q[slot] == in_addr) && (data_q[slot] == in_data);

  assign in_ready  = !full;
  assign accept    = in_valid && !full;
  assign mem_valid = (occ != '0) && ok_q[hslot];
  assign commit    = mem_valid && mem_ready;
  assign mem_addr  = addr_q[hslot];
  assign mem_data  = data_q[hslot];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seq0  <= '0;
      seq1  <= '0;
      head  <= '0;
      ok_q  <= '0;
      fault <= 1'b0;
    end else begin
      if (full && !ok_q[hslot]) fault <= 1'b1;
      if (commit) begin
        head        <= head + 1'b1;
        ok_q[hslot] <= 1'b0;
      end
      if (accept) begin
        if (in_copy) seq1 <= seq1 + 1'b1;
        else         seq0 <= seq0 + 1'b1;
        if (partner) ok_q[slot] <= same;
        else         ok_q[slot] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (accept && !partner) begin
      addr_q[slot] <= in_addr;
      data_q[slot] <= in_data;
    end
  end
endmodule

// File: rtl/dup_store_commit_buf_chk.sv
module dup_store_commit_buf_chk #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_ready,
  input logic          mem_valid,
  input logic          mem_ready,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_data,
  input logic          fault
);
  AST_RESET_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!mem_valid && !fault && in_ready)); // R1

  AST_WRITE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_data))); // R4

  AST_FAULT_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (!mem_valid && !in_ready)); // R6

  AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> fault); // R7
endmodule

bind dup_store_commit_buf dup_store_commit_buf_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .mem_valid(mem_valid),
  .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_data(mem_data), .fault(fault)
);

// File: tb/sim_dup_store_commit_buf.sv
`timescale 1ns/1ps
module sim_dup_store_commit_buf;
  localparam int D = 8, AW = 32, DW = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_copy = 1'b0, mem_ready = 1'b0;
  logic [AW-1:0] in_addr = '0;
  logic [DW-1:0] in_data = '0;
  logic in_ready, mem_valid, fault;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_data;

  dup_store_commit_buf #(.DEPTH(D), .AW(AW), .DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_copy(in_copy), .in_addr(in_addr), .in_data(in_data),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
    .mem_data(mem_data), .fault(fault));

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0, rdy_pct = 100;
  int n0, n1, hd, o, idx;
  bit acc, com, fault_m;
  logic [AW-1:0] qa[$], ea[$];
  logic [DW-1:0] qd[$], ed[$];
  bit qok[$];

  function automatic int occ_m();
    return ((n0 > n1) ? n0 : n1) - hd;
  endfunction
  function automatic bit mv_m();
    return (occ_m() > 0) ? qok[0] : 1'b0;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // reference model: pairs in a queue, indexed by sequence number minus head
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n0 = 0; n1 = 0; hd = 0; fault_m = 0;
      qa.delete(); qd.delete(); qok.delete();
    end else begin
      o   = occ_m();
      acc = in_valid && (o < D);
      com = mv_m() && mem_ready;
      if (o == D && !qok[0]) fault_m = 1;
      if (com) begin
        if (ea.size() == 0) chk("R2/R4 unexpected write", 1, 0);
        else begin
          chk("R2/R4 write addr order", mem_addr, ea[0]);
          chk("R2/R3 write data", mem_data, ed[0]);
          void'(ea.pop_front()); void'(ed.pop_front());
        end
        void'(qa.pop_front()); void'(qd.pop_front()); void'(qok.pop_front());
        hd++;
      end
      if (acc) begin
        if ((in_copy ? n1 : n0) < (in_copy ? n0 : n1)) begin
          idx = (in_copy ? n1 : n0) - hd;
          qok[idx] = (qa[idx] == in_addr) && (qd[idx] == in_data);
        end else begin
          qa.push_back(in_addr); qd.push_back(in_data); qok.push_back(1'b0);
        end
        if (in_copy) n1++; else n0++;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R6 in_ready", in_ready, occ_m() < D);
      chk("R4/R5 mem_valid", mem_valid, mv_m());
      if (mem_valid && mv_m()) begin
        chk("R3 mem_addr", mem_addr, qa[0]);
        chk("R3 mem_data", mem_data, qd[0]);
      end
      chk("R7 fault", fault, fault_m);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog R1..all actual=%0d expected<150000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic tick();
    mem_ready = ($urandom_range(99) < rdy_pct);
    @(negedge clk);
  endtask

  task automatic push(input bit c, input logic [AW-1:0] a, input logic [DW-1:0] d);
    bit got;
    in_valid = 1; in_copy = c; in_addr = a; in_data = d;
    for (int t = 0; t < 30; t++) begin
      got = in_ready;
      tick();
      if (got) break;
    end
    in_valid = 0;
  endtask

  task automatic pair(input logic [AW-1:0] a, input logic [DW-1:0] d, input bit rev);
    ea.push_back(a); ed.push_back(d);
    push(rev, a, d);
    push(!rev, a, d);
  endtask

  task automatic idle(input int n);
    in_valid = 0;
    repeat (n) tick();
  endtask

  task automatic do_reset();
    in_valid = 0; rst_n = 0;
    ea.delete(); ed.delete();
    repeat (2) tick();
    chk("R1 reset mem_valid", mem_valid, 0);
    chk("R1 reset fault", fault, 0);
    chk("R1 reset in_ready", in_ready, 1);
    rst_n = 1;
    tick();
  endtask

  initial begin
    logic [AW-1:0] ba [4];
    logic [DW-1:0] bd [4];
    int n;
    bit c;
    @(negedge clk);
    do_reset();

    // R2 R3: first copy then second copy
    rdy_pct = 100;
    for (int k = 0; k < 6; k++) pair(32'h1000 + k, 32'hA0 + k, 0);
    idle(10);
    chk("R3 all written (first-then-second)", ea.size(), 0);

    // R2: second copy leads, memory stalls at random
    rdy_pct = 50;
    for (int k = 0; k < 6; k++) pair(32'h2000 + k, 32'hB0 + k, 1);
    rdy_pct = 100; idle(10);
    chk("R2 all written (second-then-first)", ea.size(), 0);

    // R2 R4: bursts of leading copies ahead of partners
    rdy_pct = 60;
    for (int k = 0; k < 150; k++) begin
      n = $urandom_range(1, 4);
      c = $urandom_range(1);
      for (int j = 0; j < n; j++) begin
        ba[j] = $urandom; bd[j] = $urandom;
        ea.push_back(ba[j]); ed.push_back(bd[j]);
        push(c, ba[j], bd[j]);
      end
      for (int j = 0; j < n; j++) push(!c, ba[j], bd[j]);
    end
    rdy_pct = 100; idle(20);
    chk("R2/R4 bursts drained in order", ea.size(), 0);

    // R5 R7: mismatch behind a good pair blocks and fills
    pair(32'h3000, 32'h11, 0);
    idle(3);
    push(0, 32'h3001, 32'h22);
    push(1, 32'h3001, 32'h23);
    for (int k = 2; k < 9; k++) begin
      push(0, 32'h3000 + k, 32'h30 + k);
      push(1, 32'h3000 + k, 32'h30 + k);
    end
    idle(5);
    chk("R5 mismatched head blocks writes", mem_valid, 0);
    chk("R5 nothing written past bad head", ea.size(), 0);
    chk("R6 full refuses input", in_ready, 0);
    chk("R7 fault after fill behind bad head", fault, 1);
    idle(10);
    chk("R7 fault sticky", fault, 1);
    do_reset();

    // R6 R7: only first copies, partners never come
    rdy_pct = 0;
    for (int k = 0; k < D; k++) push(0, 32'h4000 + k, 32'h40 + k);
    idle(3);
    chk("R6 full of unpartnered copies", in_ready, 0);
    chk("R7 fault with missing partner", fault, 1);
    do_reset();

    // R6 R7: full with a validated head under back-pressure
    rdy_pct = 0;
    for (int k = 0; k < D - 1; k++) pair(32'h5000 + k, 32'h50 + k, k[0]);
    ea.push_back(32'h5007); ed.push_back(32'h57);
    push(0, 32'h5007, 32'h57);
    idle(3);
    chk("R6 full with validated head", in_ready, 0);
    chk("R4 validated head offered", mem_valid, 1);
    chk("R7 no fault when head validated", fault, 0);
    rdy_pct = 100; idle(12);
    push(1, 32'h5007, 32'h57);
    idle(5);
    chk("R4 drained after back-pressure", ea.size(), 0);
    chk("R7 still no fault", fault, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule